// File: doc/BRIEF.md
# Color-Scheduled Probabilistic Bit Gibbs Sampler

This block holds a small network of stochastic binary units (p-bits) and resamples them by chromatic Gibbs sampling. Each unit has a signed bias, a row of signed coupling weights to every other unit, and a color label. A sweep is split into five color slots of one clock each. In slot k, every unit labelled with color k draws a new value at the same time. The draw uses the states left by the slots before it. The coloring is worked out offline and written in, together with the weights and biases, while sampling is stopped.

A unit's new value comes from comparing its local field with a signed pseudo-random word. The local field is the bias plus the weighted spins of all other units, with each spin read as +1 or -1. Each unit has its own 16-bit LFSR to supply the random word. A sequential mode is also provided. It visits one unit per clock in index order, so a full pass takes N clocks. In both modes a one-cycle pulse marks the end of each sweep.

Top module: `pbit_gibbs_sampler`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears every spin to 0. It also clears every weight, bias and color label to 0, drops sweep_done to 0 and returns the schedule to its first slot.
- R2: A write (cfg_we high) at a clock edge with run low stores cfg_data. Addresses i*N_BITS+j hold weight w[i][j] from cfg_data[7:0] as a signed 8-bit value. Addresses N_BITS*N_BITS+i hold bias i as a signed 16-bit value. Addresses N_BITS*N_BITS+N_BITS+i hold color label i from cfg_data[2:0]. A write while run is high is dropped.
- R3: With run high and seq_mode low, successive edges step through slots for labels 0,1,2,3,4 and then repeat. In the slot for label c, every unit with label c updates at once, each from the spins held just before that edge. Units with labels 5, 6 or 7 never change in this mode.
- R4: An updating unit takes spin 1 when its local field is strictly greater than its LFSR word read as signed 16-bit, and 0 otherwise. The LFSR then advances one step only. The step is a right shift, XORed with 16'hB400 when the bit shifted out is 1. Unit i starts from seed (16'h1234 + i*16'h0101) | 1.
- R5: With run high and seq_mode high, unit i updates on the (i+1)-th edge of the pass and sees every earlier update. A pass covers N_BITS edges and then repeats from unit 0.
- R6: sweep_done is high for exactly the one cycle after the edge that served the last color slot, or the last unit in sequential mode. It is low at all other times.
- R7: While run is low, no spin changes. When run rises, the schedule starts again at the first color slot, or at unit 0.
- R8: The local field of unit i starts from its bias. The terms w[i][j]*(spin j ? +1 : -1) for every j other than i are then added one at a time in increasing j. After each addition the result saturates to [-32768, 32767].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Sampling enable; configuration writes only when low |
| seq_mode | input | 1 | 1 selects one-unit-per-clock order, 0 selects color slots |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | $clog2(N_BITS*N_BITS+2*N_BITS) | Configuration address |
| cfg_data | input | 16 | Configuration data |
| state_o | output | N_BITS | Current spin vector |
| sweep_done | output | 1 | One-cycle end-of-sweep pulse |

## Verification
The hardest case to reach from the ports is a local field that hits a saturation limit partway through its sum and then moves back. In that case step-wise clamping and a final clamp give different results. The stimulus loads weights of +127 and -128 next to biases near the 16-bit limits. A bench-side model tracks every spin and every LFSR, so each cycle compares against the exact field. Color labels that share neighbours, and the unused labels 5 to 7, are written in as well. Runs are stopped in the middle of a sweep to check the hold and the restart.

// File: rtl/gibbs_pkg.sv
package gibbs_pkg;
  localparam int W_W     = 8;
  localparam int F_W     = 16;
  localparam int LFSR_W  = 16;
  localparam int NCOLORS = 5;
  localparam int CLR_W   = 3;

  typedef logic signed [F_W-1:0] field_t;

  // add two fields, clamp to the signed range
  function automatic field_t sat_add(field_t a, field_t b);
    logic signed [F_W:0] s;
    s = {a[F_W-1], a} + {b[F_W-1], b};
    if (s[F_W] != s[F_W-1])
      return s[F_W] ? {1'b1, {(F_W-1){1'b0}}} : {1'b0, {(F_W-1){1'b1}}};
    return s[F_W-1:0];
  endfunction

  // weight times spin, spin coded as +1 (1) or -1 (0)
  function automatic field_t spin_term(logic signed [W_W-1:0] w, logic s);
    field_t wx;
    wx = {{(F_W-W_W){w[W_W-1]}}, w};
    return s ? wx : -wx;
  endfunction

  function automatic logic [LFSR_W-1:0] lfsr_next(logic [LFSR_W-1:0] s);
    return (s >> 1) ^ (s[0] ? 16'hB400 : 16'h0000);
  endfunction

  function automatic logic [LFSR_W-1:0] seed_of(int unsigned i);
    return (16'h1234 + LFSR_W'(i) * 16'h0101) | 16'h0001;
  endfunction
endpackage

// File: rtl/gibbs_sched.sv
module gibbs_sched #(
  parameter int N_BITS  = 8,
  parameter int NCOLORS = 5,
  localparam int IDX_W  = (N_BITS > 1) ? $clog2(N_BITS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               seq_mode,
  output logic [NCOLORS-1:0] slot_oh,
  output logic [IDX_W-1:0]   seq_idx,
  output logic               sweep_end,
  output logic               done
);
  assign sweep_end = run && (seq_mode ? (seq_idx == IDX_W'(N_BITS-1))
                                      : slot_oh[NCOLORS-1]);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      slot_oh <= NCOLORS'(1);
      seq_idx <= '0;
    end else begin
      slot_oh <= {slot_oh[NCOLORS-2:0], slot_oh[NCOLORS-1]};
      seq_idx <= (seq_idx == IDX_W'(N_BITS-1)) ? '0 : seq_idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= sweep_end;
  end
endmodule

// File: rtl/gibbs_lfsr.sv
module gibbs_lfsr
  import gibbs_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 16'h0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  output logic [LFSR_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= SEED;
    else if (en) q <= lfsr_next(q);
  end
endmodule

// File: rtl/gibbs_field.sv
module gibbs_field
  import gibbs_pkg::*;
#(
  parameter int N_BITS = 8,
  parameter int SELF   = 0
) (
  input  logic [N_BITS*W_W-1:0] w_row,
  input  field_t                bias,
  input  logic [N_BITS-1:0]     spins,
  output field_t                field
);
  always_comb begin
    field = bias;
    for (int j = 0; j < N_BITS; j++) begin
      if (j != SELF)
        field = sat_add(field, spin_term(w_row[j*W_W +: W_W], spins[j]));
    end
  end
endmodule

// File: rtl/pbit_gibbs_sampler.sv
module pbit_gibbs_sampler
  import gibbs_pkg::*;
#(
  parameter int N_BITS   = 8,
  localparam int ADDR_W  = $clog2(N_BITS*N_BITS + 2*N_BITS),
  localparam int IDX_W   = (N_BITS > 1) ? $clog2(N_BITS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              seq_mode,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [15:0]       cfg_data,
  output logic [N_BITS-1:0] state_o,
  output logic              sweep_done
);
  localparam int BIAS_BASE = N_BITS*N_BITS;
  localparam int CLR_BASE  = N_BITS*N_BITS + N_BITS;

  logic [N_BITS*W_W-1:0] w_rows  [N_BITS];
  field_t                bias_r  [N_BITS];
  logic [CLR_W-1:0]      color_r [N_BITS];

  logic [NCOLORS-1:0]    slot_oh;
  logic [IDX_W-1:0]      seq_idx;
  logic                  sweep_end;
  logic [N_BITS-1:0]     upd;
  logic [N_BITS-1:0]     new_val;
  logic [N_BITS-1:0]     spin;
  logic                  cfg_take;

  assign cfg_take = cfg_we && !run;

  // configuration storage, written only while halted
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_BITS; i++) begin
        w_rows[i]  <= '0;
        bias_r[i]  <= '0;
        color_r[i] <= '0;
      end
    end else if (cfg_take) begin
      for (int i = 0; i < N_BITS; i++) begin
        for (int j = 0; j < N_BITS; j++) begin
          if (cfg_addr == ADDR_W'(i*N_BITS + j))
            w_rows[i][j*W_W +: W_W] <= cfg_data[W_W-1:0];
        end
        if (cfg_addr == ADDR_W'(BIAS_BASE + i)) bias_r[i]  <= cfg_data;
        if (cfg_addr == ADDR_W'(CLR_BASE + i))  color_r[i] <= cfg_data[CLR_W-1:0];
      end
    end
  end

  gibbs_sched #(.N_BITS(N_BITS), .NCOLORS(NCOLORS)) u_sched (
    .clk(clk), .rst(rst), .run(run), .seq_mode(seq_mode),
    .slot_oh(slot_oh), .seq_idx(seq_idx), .sweep_end(sweep_end),
    .done(sweep_done)
  );

  for (genvar i = 0; i < N_BITS; i++) begin : g_pbit
    field_t              field;
    logic [LFSR_W-1:0]   rnd;
    logic                hit;

    gibbs_field #(.N_BITS(N_BITS), .SELF(i)) u_field (
      .w_row(w_rows[i]), .bias(bias_r[i]), .spins(spin), .field(field)
    );

    gibbs_lfsr #(.SEED(seed_of(i))) u_lfsr (
      .clk(clk), .rst(rst), .en(upd[i]), .q(rnd)
    );

    always_comb begin
      hit = 1'b0;
      for (int c = 0; c < NCOLORS; c++) begin
        if (color_r[i] == CLR_W'(c) && slot_oh[c]) hit = 1'b1;
      end
    end

    assign upd[i]     = run && (seq_mode ? (seq_idx == IDX_W'(i)) : hit);
    assign new_val[i] = field > $signed(rnd);
  end

  always_ff @(posedge clk) begin
    if (rst) spin <= '0;
    else begin
      for (int i = 0; i < N_BITS; i++) begin
        if (upd[i]) spin[i] <= new_val[i];
      end
    end
  end

  assign state_o = spin;
endmodule

// File: rtl/gibbs_sva.sv
module gibbs_sva #(
  parameter int N_BITS  = 8,
  parameter int NCOLORS = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               run,
  input logic               seq_mode,
  input logic [NCOLORS-1:0] slot_oh,
  input logic [N_BITS-1:0]  upd,
  input logic [N_BITS-1:0]  spin,
  input logic               done
);
  p_slot_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $countones(slot_oh) == 1);

  p_slot_rotate_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(run) && !$past(rst)) |->
      slot_oh == {$past(slot_oh[NCOLORS-2:0]), $past(slot_oh[NCOLORS-1])});

  p_seq_single_r5: assert property (@(posedge clk) disable iff (rst)
    (run && seq_mode) |-> $countones(upd) == 1);

  p_halt_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(spin));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    (done && !seq_mode) |=> !done);

  p_done_after_run_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(run));
endmodule

bind pbit_gibbs_sampler gibbs_sva #(.N_BITS(N_BITS), .NCOLORS(gibbs_pkg::NCOLORS)) u_sva (
  .clk(clk), .rst(rst), .run(run), .seq_mode(seq_mode),
  .slot_oh(slot_oh), .upd(upd), .spin(state_o), .done(sweep_done)
);

// File: tb/tb_pbit_gibbs_sampler.sv
module tb_pbit_gibbs_sampler;
  localparam int N = 8;
  localparam int AW = $clog2(N*N + 2*N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          run = 1'b0;
  logic          seq_mode = 1'b0;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [15:0]   cfg_data = '0;
  wire  [N-1:0]  state_o;
  wire           sweep_done;

  pbit_gibbs_sampler #(.N_BITS(N)) dut (
    .clk(clk), .rst(rst), .run(run), .seq_mode(seq_mode), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .state_o(state_o),
    .sweep_done(sweep_done)
  );

  always #2 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  // reference model
  int m_w [N][N];
  int m_bias [N];
  int m_col [N];
  int m_lfsr [N];
  bit [N-1:0] m_spin;
  int m_slot, m_idx;
  bit m_done;
  int unsigned lcg = 32'd12345;

  function automatic int rnd_range(int lo, int hi);
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lo + int'((lcg >> 16) % (hi - lo + 1));
  endfunction

  function automatic int clamp16(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int field_of(int i, bit [N-1:0] s);
    int acc = m_bias[i];
    for (int j = 0; j < N; j++)
      if (j != i) acc = clamp16(acc + (s[j] ? m_w[i][j] : -m_w[i][j]));
    return acc;
  endfunction

  function automatic int as_signed16(int v);
    return (v >= 32768) ? v - 65536 : v;
  endfunction

  function automatic int step_lfsr(int v);
    return (v % 2 == 1) ? ((v / 2) ^ 32'hB400) : (v / 2);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) m_w[i][j] = 0;
      m_bias[i] = 0;
      m_col[i]  = 0;
      m_lfsr[i] = ((32'h1234 + i * 32'h0101) & 32'hFFFF) | 1;
    end
    m_spin = '0; m_slot = 0; m_idx = 0; m_done = 0;
  endtask

  task automatic model_edge();
    bit [N-1:0] old;
    if (rst) begin model_reset(); return; end
    if (cfg_we && !run) begin
      int a = int'(cfg_addr);
      if (a < N*N) begin
        int v = int'(cfg_data[7:0]);
        m_w[a / N][a % N] = (v >= 128) ? v - 256 : v;
      end else if (a < N*N + N) m_bias[a - N*N] = as_signed16(int'(cfg_data));
      else if (a < N*N + 2*N)   m_col[a - N*N - N] = int'(cfg_data[2:0]);
    end
    if (!run) begin
      m_slot = 0; m_idx = 0; m_done = 0;
      return;
    end
    old = m_spin;
    m_done = seq_mode ? (m_idx == N-1) : (m_slot == 4);
    for (int i = 0; i < N; i++) begin
      bit go = seq_mode ? (i == m_idx) : (m_col[i] == m_slot);
      if (go) begin
        // sequential mode: earlier bits already in m_spin
        bit [N-1:0] src = seq_mode ? m_spin : old;
        m_spin[i] = field_of(i, src) > as_signed16(m_lfsr[i]);
        m_lfsr[i] = step_lfsr(m_lfsr[i]);
      end
    end
    m_slot = (m_slot + 1) % 5;
    m_idx  = (m_idx + 1) % N;
  endtask

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(state_o == m_spin, tag, "state", int'(state_o), int'(m_spin));
    check(sweep_done == m_done, "R6", "sweep_done", int'(sweep_done), int'(m_done));
  endtask

  task automatic wr(int a, int d, string tag);
    cfg_we = 1'b1; cfg_addr = AW'(a); cfg_data = 16'(d);
    step(tag);
    cfg_we = 1'b0;
  endtask

  // kind 0: moderate random, 1: high saturation, 2: low saturation, 3: mixed edge
  task automatic load(int kind, int col_kind);
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        int w;
        case (kind)
          1: w = 127;
          2: w = -128;
          3: w = rnd_range(0, 1) ? 127 : -128;
          default: w = rnd_range(-40, 40);
        endcase
        wr(i*N + j, w & 255, "R2");
      end
    end
    for (int i = 0; i < N; i++) begin
      int b;
      case (kind)
        1: b = 32600;
        2: b = -32600;
        3: b = (i % 2 == 1) ? 32767 : -32768;
        default: b = rnd_range(-200, 200);
      endcase
      wr(N*N + i, b & 16'hFFFF, "R2");
    end
    for (int i = 0; i < N; i++) begin
      int c = (col_kind == 0) ? (i % 5) : ((i % 2 == 0) ? (i / 2) % 5 : 5 + (i % 3));
      wr(N*N + N + i, c, "R2");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    @(negedge clk);
    repeat (3) step("R1");
    rst = 1'b0;
    repeat (3) step("R1");
    check(state_o == '0, "R1", "reset state", int'(state_o), 0);
    check(sweep_done == 1'b0, "R1", "reset done", int'(sweep_done), 0);

    // colored sweeps with a proper palette
    load(0, 0);
    run = 1'b1;
    repeat (60) step("R3");
    run = 1'b0;
    repeat (4) step("R7");

    // decision rule at the extremes of the field
    for (int i = 0; i < N; i++) wr(N*N + i, 16'h7FFF, "R4");
    for (int i = 0; i < N*N; i++) wr(i, 0, "R4");
    run = 1'b1; repeat (20) step("R4"); run = 1'b0; step("R7");
    for (int i = 0; i < N; i++) wr(N*N + i, 16'h8000, "R4");
    run = 1'b1; repeat (20) step("R4"); run = 1'b0; step("R7");
    check(state_o == '0, "R4", "floor field gives zero", int'(state_o), 0);

    // saturation of the local field
    for (int k = 1; k <= 3; k++) begin
      load(k, 0);
      run = 1'b1; repeat (40) step("R8"); run = 1'b0; step("R7");
    end
    for (int r = 0; r < 4; r++) begin
      load(3, 0);
      run = 1'b1; repeat (25) step("R8"); run = 1'b0; step("R7");
    end

    // unused labels and shared colors
    load(0, 1);
    run = 1'b1; repeat (50) step("R3"); run = 1'b0; step("R7");

    // halt in the middle of a colored sweep, then restart
    load(0, 0);
    for (int r = 0; r < 5; r++) begin
      run = 1'b1; repeat (3 + r) step("R3");
      run = 1'b0; repeat (3) step("R7");
    end

    // sequential mode
    seq_mode = 1'b1;
    run = 1'b1; repeat (3*N) step("R5");
    run = 1'b0; repeat (4) step("R7");
    run = 1'b1; repeat (5) step("R5");
    run = 1'b0; repeat (2) step("R7");
    run = 1'b1; repeat (2*N) step("R5");
    run = 1'b0; step("R7");
    seq_mode = 1'b0;

    // writes during sampling are dropped
    run = 1'b1;
    for (int i = 0; i < N; i++) wr(N*N + i, 16'h7FFF, "R2");
    for (int i = 0; i < N; i++) wr(N*N + N + i, 7, "R2");
    repeat (20) step("R2");
    run = 1'b0; step("R7");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule